// File: doc/BRIEF.md
# Counted Byte Block-Move Engine

This block copies a run of bytes inside a byte-wide memory. A single-cycle start pulse loads a 16-bit source pointer, a 16-bit destination pointer and an 8-bit byte count. The engine then reads one byte at the source, writes it at the destination, advances both pointers, lowers the count, and repeats until the count is exhausted. A count of zero finishes with no memory traffic at all.

The run length is fixed by the count alone. Each byte costs four cycles: read request, read capture, write, and register update. A fixed setup and completion overhead adds nine cycles, or eight when the short-tail input is high at start. This lets the engine match a known timing budget exactly. When the one-cycle done pulse is high, the final pointer and count values are on the outputs, so a host register file can take them in that cycle.

Top module: `blkmv_engine`

## Requirements
- R1: After synchronous reset, busy, done, rd_en and wr_en are all 0.
- R2: A start pulse while idle loads src_init, dst_init and cnt_init into the working registers. busy is 1 from the cycle after start.
- R3: If the loaded count is 0, rd_en and wr_en stay 0 for the whole run, and src_out, dst_out and cnt_out keep the loaded values.
- R4: Memory reads have one cycle of latency: rd_data is valid in the cycle after rd_en. Each byte returned for a read at rd_addr is written, two cycles after its rd_en, on wr_data at wr_addr.
- R5: After each byte, the source and destination pointers each rise by 1, wrapping modulo 2^16, and the count falls by 1.
- R6: For a starting count n, exactly n reads at src, src+1, and so on, and n writes at dst, dst+1, and so on, happen in ascending order.
- R7: busy stays high for exactly 4n+9 cycles when short_tail was 0 at start, and for 4n+8 cycles when it was 1.
- R8: done is a single-cycle pulse in the last busy cycle. While done is high, src_out = src_init+n, dst_out = dst_init+n and cnt_out = 0.
- R9: A start pulse while busy has no effect on the run in progress, its traffic, or its results.
- R10: rd_en and wr_en are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a move |
| short_tail | input | 1 | When 1 at start, the fixed overhead is 8 cycles instead of 9 |
| src_init | input | 16 | Initial source pointer |
| dst_init | input | 16 | Initial destination pointer |
| cnt_init | input | 8 | Initial byte count |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | 16 | Memory read address |
| rd_data | input | 8 | Read data, valid the cycle after rd_en |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | 16 | Memory write address |
| wr_data | output | 8 | Memory write data |
| src_out | output | 16 | Current and final source pointer |
| dst_out | output | 16 | Current and final destination pointer |
| cnt_out | output | 8 | Current and final count |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
busy rises one cycle after the start edge and then lasts exactly 4n+9 or 4n+8 cycles. done falls in the last of those cycles, and each write comes two cycles after the read that fed it. The bench drives every input on the falling edge. It counts busy cycles by sampling busy, done and the result ports on each falling edge, so every value is read half a cycle after the edge that produced it. Read and write strobes are logged on rising edges and compared afterwards against addresses and data computed from the start values. The memory model answers reads one cycle late, which gives the latency stated in R4.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;

    localparam int DEF_ADDR_W    = 16;
    localparam int DEF_CNT_W     = 8;
    localparam int DEF_DATA_W    = 8;
    localparam int DEF_SETUP_CYC = 4;
    localparam int DEF_TAIL_LONG = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_RADDR,
        S_RCAP,
        S_WRITE,
        S_UPD,
        S_TAIL
    } mv_state_e;

    typedef struct packed {
        logic load;
        logic capture;
        logic step;
    } mv_ctl_t;

    // Cycle budget of one move: four per byte plus the fixed overhead.
    function automatic int run_len(input int n, input logic short_sel,
                                   input int setup_cyc, input int tail_long);
        return 4 * n + setup_cyc + (short_sel ? tail_long - 1 : tail_long);
    endfunction

endpackage

// File: rtl/blkmv_seq.sv
module blkmv_seq
    import blkmv_pkg::*;
#(
    parameter int SETUP_CYC = DEF_SETUP_CYC,
    parameter int TAIL_LONG = DEF_TAIL_LONG
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      short_tail,
    input  logic      cnt_zero,
    input  logic      cnt_one,
    output mv_state_e state,
    output mv_ctl_t   ctl,
    output logic      busy,
    output logic      done
);
    localparam int PAD_MAX = (SETUP_CYC > TAIL_LONG) ? SETUP_CYC : TAIL_LONG;
    localparam int PAD_W   = $clog2(PAD_MAX + 1);
    localparam logic [PAD_W-1:0] SETUP_LAST = PAD_W'(SETUP_CYC - 1);
    localparam logic [PAD_W-1:0] TAIL_LAST  = PAD_W'(TAIL_LONG - 1);
    localparam logic [PAD_W-1:0] TAIL_SLAST = PAD_W'(TAIL_LONG - 2);
    localparam logic [PAD_W-1:0] PAD_ONE    = PAD_W'(1);

    mv_state_e        state_q, state_d;
    logic [PAD_W-1:0] pad_q, pad_d;
    logic             short_q;
    logic [PAD_W-1:0] tail_first;

    assign tail_first = short_q ? TAIL_SLAST : TAIL_LAST;

    always_comb begin
        state_d = state_q;
        pad_d   = pad_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = S_SETUP;
                    pad_d   = SETUP_LAST;
                end
            end
            S_SETUP: begin
                if (pad_q == '0) begin
                    if (cnt_zero) begin
                        state_d = S_TAIL;
                        pad_d   = tail_first;
                    end else begin
                        state_d = S_RADDR;
                    end
                end else begin
                    pad_d = pad_q - PAD_ONE;
                end
            end
            S_RADDR: state_d = S_RCAP;
            S_RCAP:  state_d = S_WRITE;
            S_WRITE: state_d = S_UPD;
            S_UPD: begin
                if (cnt_one) begin
                    state_d = S_TAIL;
                    pad_d   = tail_first;
                end else begin
                    state_d = S_RADDR;
                end
            end
            S_TAIL: begin
                if (pad_q == '0) state_d = S_IDLE;
                else             pad_d   = pad_q - PAD_ONE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            pad_q   <= '0;
            short_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pad_q   <= pad_d;
            if (state_q == S_IDLE && start) short_q <= short_tail;
        end
    end

    assign state       = state_q;
    assign ctl.load    = (state_q == S_IDLE) && start;
    assign ctl.capture = (state_q == S_RCAP);
    assign ctl.step    = (state_q == S_UPD);
    assign busy        = (state_q != S_IDLE);
    assign done        = (state_q == S_TAIL) && (pad_q == '0);

    // The completion pulse is always the final busy cycle.
    p_done_last_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // The engine leaves idle only on a start request.
    p_leave_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> !busy);
endmodule

// File: rtl/blkmv_regs.sv
module blkmv_regs
    import blkmv_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  mv_ctl_t           ctl,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [DATA_W-1:0] byte_q,
    output logic              cnt_zero,
    output logic              cnt_one
);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            byte_q <= '0;
        end else begin
            if (ctl.load) begin
                src_q <= src_init;
                dst_q <= dst_init;
                cnt_q <= cnt_init;
            end else if (ctl.step) begin
                src_q <= src_q + ADDR_ONE;
                dst_q <= dst_q + ADDR_ONE;
                cnt_q <= cnt_q - CNT_ONE;
            end
            if (ctl.capture) byte_q <= rd_data;
        end
    end

    assign cnt_zero = (cnt_q == '0);
    assign cnt_one  = (cnt_q == CNT_ONE);

    // Each update advances both pointers by one and lowers the count by one.
    p_step_adv_r5: assert property (@(posedge clk) disable iff (rst)
        ctl.step |=> (src_q == $past(src_q) + ADDR_ONE)
                  && (dst_q == $past(dst_q) + ADDR_ONE)
                  && (cnt_q == $past(cnt_q) - CNT_ONE));
    // An update is never issued on an empty count.
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        ctl.step |-> !cnt_zero);
endmodule

// File: rtl/blkmv_engine.sv
module blkmv_engine
    import blkmv_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int CNT_W     = DEF_CNT_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int SETUP_CYC = DEF_SETUP_CYC,
    parameter int TAIL_LONG = DEF_TAIL_LONG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              short_tail,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic [CNT_W-1:0]  cnt_init,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] src_out,
    output logic [ADDR_W-1:0] dst_out,
    output logic [CNT_W-1:0]  cnt_out,
    output logic              busy,
    output logic              done
);
    localparam int LEN_W = CNT_W + 6;

    mv_state_e         state;
    mv_ctl_t           ctl;
    logic              cnt_zero, cnt_one;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] byte_q;

    blkmv_seq #(
        .SETUP_CYC (SETUP_CYC),
        .TAIL_LONG (TAIL_LONG)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .short_tail (short_tail),
        .cnt_zero   (cnt_zero),
        .cnt_one    (cnt_one),
        .state      (state),
        .ctl        (ctl),
        .busy       (busy),
        .done       (done)
    );

    blkmv_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .src_init (src_init),
        .dst_init (dst_init),
        .cnt_init (cnt_init),
        .rd_data  (rd_data),
        .src_q    (src_q),
        .dst_q    (dst_q),
        .cnt_q    (cnt_q),
        .byte_q   (byte_q),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    assign rd_en   = (state == S_RADDR);
    assign rd_addr = src_q;
    assign wr_en   = (state == S_WRITE);
    assign wr_addr = dst_q;
    assign wr_data = byte_q;
    assign src_out = src_q;
    assign dst_out = dst_q;
    assign cnt_out = cnt_q;

    // Run-length checker: counts busy cycles and compares them with the budget.
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] n0_q;
    logic             sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            n0_q  <= '0;
            sh_q  <= 1'b0;
        end else if (ctl.load) begin
            len_q <= '0;
            n0_q  <= cnt_init;
            sh_q  <= short_tail;
        end else if (busy) begin
            len_q <= len_q + LEN_W'(1);
        end
    end

    p_budget_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (int'(len_q) + 1 == run_len(int'(n0_q), sh_q, SETUP_CYC, TAIL_LONG)));
    p_excl_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));
    p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en) |-> $past(rd_en, 2));
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !ctl.step) |=> ($stable(src_out) && $stable(dst_out) && $stable(cnt_out)));
    p_done_empty_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt_out == '0));
endmodule

// File: tb/blkmv_engine_test.sv
`timescale 1ns/1ps
module blkmv_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        short_tail = 1'b0;
    logic [15:0] src_init = '0, dst_init = '0;
    logic [7:0]  cnt_init = '0;
    logic        rd_en, wr_en, busy, done;
    logic [15:0] rd_addr, wr_addr, src_out, dst_out;
    logic [7:0]  rd_data = '0, wr_data, cnt_out;

    int tests = 0, failed = 0;

    always #2.5 clk = ~clk;

    blkmv_engine uut (
        .clk(clk), .rst(rst), .start(start), .short_tail(short_tail),
        .src_init(src_init), .dst_init(dst_init), .cnt_init(cnt_init),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out),
        .busy(busy), .done(done)
    );

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h5A;
    endfunction

    // Memory model with one cycle of read latency, plus traffic logs.
    logic [15:0] rd_log [0:255];
    logic [15:0] wr_log_a [0:255];
    logic [7:0]  wr_log_d [0:255];
    int rd_n = 0, wr_n = 0, both_n = 0;

    always @(posedge clk) begin
        if (rd_en) begin
            rd_data <= mem_f(rd_addr);
            if (rd_n < 256) rd_log[rd_n] <= rd_addr;
            rd_n <= rd_n + 1;
        end
        if (wr_en) begin
            if (wr_n < 256) begin
                wr_log_a[wr_n] <= wr_addr;
                wr_log_d[wr_n] <= wr_data;
            end
            wr_n <= wr_n + 1;
        end
        if (rd_en && wr_en) both_n <= both_n + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Runs one move and checks length, traffic and results.
    // poke_at > 0 raises start with other values during that busy cycle.
    task automatic run_move(input logic [15:0] s, input logic [15:0] d,
                            input logic [7:0] n, input logic sh, input int poke_at);
        int blen = 0, dones = 0, done_at = 0;
        logic [15:0] fs = '0, fd = '0;
        logic [7:0]  fc = 8'hFF;
        int exp_len;
        @(negedge clk);
        rd_n = 0; wr_n = 0; both_n = 0;
        src_init = s; dst_init = d; cnt_init = n; short_tail = sh; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R2", "busy after start", busy, 1);
        while (busy && blen < 2000) begin
            blen++;
            if (done) begin
                dones++; done_at = blen;
                fs = src_out; fd = dst_out; fc = cnt_out;
            end
            if (poke_at != 0 && blen == poke_at) begin
                src_init = ~s; dst_init = ~d; cnt_init = n + 8'd3;
                short_tail = ~sh; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        exp_len = 4 * int'(n) + (sh ? 8 : 9);
        chk(blen == exp_len, "R7", "busy length", blen, exp_len);
        chk(dones == 1, "R8", "done pulses", dones, 1);
        chk(done_at == blen, "R8", "done in last busy cycle", done_at, blen);
        chk(fs == s + 16'(n), "R8", "final src", fs, s + 16'(n));
        chk(fd == d + 16'(n), "R8", "final dst", fd, d + 16'(n));
        chk(fc == 8'd0, "R8", "final count", fc, 0);
        chk(rd_n == int'(n), "R6", "read count", rd_n, n);
        chk(wr_n == int'(n), "R6", "write count", wr_n, n);
        chk(both_n == 0, "R10", "strobes overlap", both_n, 0);
        for (int i = 0; i < int'(n) && i < rd_n && i < wr_n; i++) begin
            chk(rd_log[i] == s + 16'(i), "R5", "read address", rd_log[i], s + 16'(i));
            chk(wr_log_a[i] == d + 16'(i), "R5", "write address", wr_log_a[i], d + 16'(i));
            chk(wr_log_d[i] == mem_f(s + 16'(i)), "R4", "write data",
                wr_log_d[i], mem_f(s + 16'(i)));
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        chk(rd_en == 0, "R1", "rd_en", rd_en, 0);
        chk(wr_en == 0, "R1", "wr_en", wr_en, 0);
    endtask

    task automatic t_zero();
        run_move(16'h1234, 16'h8000, 8'd0, 1'b0, 0);  // R3 long tail
        run_move(16'hABCD, 16'h0100, 8'd0, 1'b1, 0);  // R3 short tail
    endtask

    task automatic t_single();  run_move(16'h0040, 16'h0200, 8'd1, 1'b0, 0); endtask
    task automatic t_burst();   run_move(16'h3000, 16'h5000, 8'd6, 1'b1, 0); endtask
    task automatic t_wrap();    run_move(16'hFFFE, 16'hFFFD, 8'd4, 1'b0, 0); endtask
    task automatic t_max();     run_move(16'h7F80, 16'hC000, 8'd255, 1'b1, 0); endtask
    task automatic t_busy_start();  // R9
        run_move(16'h0900, 16'h0A00, 8'd5, 1'b0, 3);
        run_move(16'h0010, 16'h0020, 8'd2, 1'b1, 12);
    endtask

    initial begin
        #(200000 * 5);
        tests++; failed++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_zero();
        t_single();
        t_burst();
        t_wrap();
        t_max();
        t_busy_start();
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    end
endmodule